// File: doc/BRIEF.md
# Error-Tagged Receive Queue with Fill Index

This block holds received characters for a serial port until bus software reads them. Each stored entry is ten bits wide: the eight data bits plus a parity error tag and a framing error tag, so every error stays attached to the character it arrived with. Next to the queue is an occupancy counter for the transmit side. The bytes themselves live elsewhere; only their count is kept here. Both fill levels are packed into one index word. A small control word enables queue mode and starts a separate self-clearing flush for each direction. The interrupt logic uses the level flags and a one-cycle overrun pulse.

Characters enter on a valid/ready stream from the receiver. The receiver cannot stall. If it presents a character while `rx_in_ready` is low, the character is lost and an overrun is reported. The bus read of the queue window is the output stream: `rx_out_valid` means the head entry is presented, and a cycle with `rx_out_valid` and `rx_out_ready` both high removes it. Holding `rx_out_ready` high while the queue is empty removes nothing. Transmit writes use `tx_wr_valid`/`tx_wr_ready` in the same way, and a write offered while ready is low is dropped. `tx_take` is a plain strobe from the transmitter.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `fifo_index`, `fcr_rdata`, `rx_out_data`, `rx_out_valid`, `rx_overrun` and `rx_almost_full` are 0, and `tx_empty` and `tx_almost_empty` are 1.
- R2: Entries leave in the order they were accepted. `rx_out_data` bits 7:0 hold the character, bit 8 holds its parity error tag and bit 9 holds its framing error tag.
- R3: `fifo_index` bits 4:0 give the transmit count and bits 12:8 give the receive count. Both counts lie in 0..DEPTH (16), and every other bit reads 0.
- R4: A push while `rx_in_ready` is low (queue full) is discarded. `rx_overrun` is high for exactly the one cycle after that edge. The count and the stored entries do not change.
- R5: With the queue empty, `rx_out_valid` is 0, `rx_out_data` reads 0, and holding `rx_out_ready` high does not change the count.
- R6: `rx_almost_full` is 1 exactly when the receive count is 12 or more.
- R7: An accepted transmit write adds one to the transmit count and `tx_take` subtracts one. A write while `tx_wr_ready` is low (count at capacity) is ignored, and `tx_take` at count 0 is ignored.
- R8: `tx_almost_empty` is 1 when the transmit count is 4 or fewer, and `tx_empty` is 1 when it is 0.
- R9: Writing the control word with bit 3 set empties the receive queue by the next cycle. With bit 2 set, the transmit count is cleared the same way. The matching `fcr_rdata` bit reads 1 for RST_CYCLES (4) cycles after the write and then clears itself. The other direction is not touched.
- R10: Control bit 0 selects queue mode: `fcr_rdata[0]` reads it back. With it at 0 each direction holds one entry, and with it at 1 each holds DEPTH entries.
- R11: A push and a pop in the same cycle on a queue that is not full leave the count unchanged, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in_valid | input | 1 | Receiver presents a character |
| rx_in_ready | output | 1 | Queue can accept a character this cycle |
| rx_in_data | input | 8 | Received character |
| rx_in_perr | input | 1 | Parity error for the character |
| rx_in_ferr | input | 1 | Framing error for the character |
| rx_out_valid | output | 1 | Head entry is presented |
| rx_out_ready | input | 1 | Bus read of the queue window; pops when valid |
| rx_out_data | output | 10 | Head entry {ferr, perr, data}, 0 when empty |
| tx_wr_valid | input | 1 | Bus write to the transmit window |
| tx_wr_ready | output | 1 | Transmit side has room |
| tx_take | input | 1 | Transmitter consumed one byte |
| fcr_wr | input | 1 | Control word write strobe |
| fcr_wdata | input | 4 | Control word: bit 0 mode, bit 2 transmit flush, bit 3 receive flush |
| fcr_rdata | output | 4 | Control readback: mode, flush-busy bits |
| fifo_index | output | 16 | Packed fill levels |
| rx_overrun | output | 1 | One-cycle overrun pulse |
| rx_almost_full | output | 1 | Receive count at or above 12 |
| rx_full | output | 1 | Receive count at capacity |
| tx_almost_empty | output | 1 | Transmit count at or below 4 |
| tx_empty | output | 1 | Transmit count zero |

## Verification
The bench drives the queue to exactly full and then pushes once more. A design that overwrote an entry or advanced its write pointer on overrun would return a wrong character or a shifted order when the queue is drained. Mixed error tags across the fill expose a swapped bit 8/9 layout. Probes at count 11 and 12, and at transmit count 4 and 5, catch off-by-one thresholds. Reads of an empty queue catch a count that wraps below zero. A flush in one direction while the other holds data catches flushes that leak across, or a busy bit that never clears or clears too early. The single-entry mode catches a capacity that ignores the mode bit.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
  localparam int unsigned CHAR_W = 8;

  // Receive entry layout: framing tag above parity tag above data.
  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  localparam int unsigned ENTRY_W = $bits(rx_entry_t);

  // Control word bit positions.
  localparam int unsigned CTL_MODE_BIT  = 0;
  localparam int unsigned CTL_TXRST_BIT = 2;
  localparam int unsigned CTL_RXRST_BIT = 3;
  localparam int unsigned CTL_W         = 4;

  // Index word field placement.
  localparam int unsigned IDX_W      = 16;
  localparam int unsigned IDX_TX_LSB = 0;
  localparam int unsigned IDX_RX_LSB = 8;

  // Flush channels, in control-bit order starting at CTL_TXRST_BIT.
  localparam int unsigned CH_TX = 0;
  localparam int unsigned CH_RX = 1;
  localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/efifo_flush_seq.sv
module efifo_flush_seq #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= CW'(CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/efifo_store.sv
module efifo_store
  import efifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] cap,
  input  logic             push_valid,
  output logic             push_ready,
  input  rx_entry_t        push_entry,
  output logic             pop_valid,
  input  logic             pop_ready,
  output rx_entry_t        pop_entry,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign push_ready = !clr && (cnt_q < cap);
  assign pop_valid  = !clr && (cnt_q != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;
  assign pop_entry  = pop_valid ? mem_q[rd_q] : '0;
  assign count      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // Storage has no reset: only written slots are ever presented.
  always_ff @(posedge clk) begin
    if (do_push && !clr) mem_q[wr_q] <= push_entry;
  end
endmodule

// File: rtl/efifo_occ.sv
module efifo_occ #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] cap,
  input  logic             inc_valid,
  output logic             inc_ready,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;
  logic             do_inc, do_dec;

  assign inc_ready = !clr && (cnt_q < cap);
  assign do_inc    = inc_valid && inc_ready;
  assign do_dec    = dec && !clr && (cnt_q != '0);
  assign count     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (do_inc && !do_dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (do_dec && !do_inc) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import efifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned RX_AF_LEVEL = 12,
  parameter int unsigned TX_AE_LEVEL = 4,
  parameter int unsigned RST_CYCLES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_in_valid,
  output logic               rx_in_ready,
  input  logic [CHAR_W-1:0]  rx_in_data,
  input  logic               rx_in_perr,
  input  logic               rx_in_ferr,
  output logic               rx_out_valid,
  input  logic               rx_out_ready,
  output logic [ENTRY_W-1:0] rx_out_data,
  input  logic               tx_wr_valid,
  output logic               tx_wr_ready,
  input  logic               tx_take,
  input  logic               fcr_wr,
  input  logic [CTL_W-1:0]   fcr_wdata,
  output logic [CTL_W-1:0]   fcr_rdata,
  output logic [IDX_W-1:0]   fifo_index,
  output logic               rx_overrun,
  output logic               rx_almost_full,
  output logic               rx_full,
  output logic               tx_almost_empty,
  output logic               tx_empty
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned GAP_W = IDX_RX_LSB - CNT_W;
  localparam int unsigned TOP_W = IDX_W - IDX_RX_LSB - CNT_W;

  logic             mode_q;
  logic             ovr_q;
  logic [CNT_W-1:0] cap;
  logic [N_CH-1:0]  flush_start, flush_busy, flush_clr;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  rx_entry_t        in_entry, out_entry;

  // Control word: mode bit stored, flush bits launch sequencers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (fcr_wr) mode_q <= fcr_wdata[CTL_MODE_BIT];
  end

  assign cap = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_flush
    assign flush_start[ch] = fcr_wr && fcr_wdata[CTL_TXRST_BIT + ch];
    efifo_flush_seq #(.CYCLES(RST_CYCLES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (flush_start[ch]),
      .busy  (flush_busy[ch])
    );
    assign flush_clr[ch] = flush_start[ch] || flush_busy[ch];
  end

  always_comb begin
    fcr_rdata                = '0;
    fcr_rdata[CTL_MODE_BIT]  = mode_q;
    fcr_rdata[CTL_TXRST_BIT] = flush_busy[CH_TX];
    fcr_rdata[CTL_RXRST_BIT] = flush_busy[CH_RX];
  end

  // Receive queue.
  assign in_entry = '{ferr: rx_in_ferr, perr: rx_in_perr, data: rx_in_data};

  efifo_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (flush_clr[CH_RX]),
    .cap        (cap),
    .push_valid (rx_in_valid),
    .push_ready (rx_in_ready),
    .push_entry (in_entry),
    .pop_valid  (rx_out_valid),
    .pop_ready  (rx_out_ready),
    .pop_entry  (out_entry),
    .count      (rx_cnt)
  );

  assign rx_out_data = out_entry;

  // Overrun: receiver offered a character the queue could not take.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= rx_in_valid && !rx_in_ready && !flush_clr[CH_RX];
  end
  assign rx_overrun = ovr_q;

  // Transmit occupancy.
  efifo_occ #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_txc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush_clr[CH_TX]),
    .cap       (cap),
    .inc_valid (tx_wr_valid),
    .inc_ready (tx_wr_ready),
    .dec       (tx_take),
    .count     (tx_cnt)
  );

  // Level flags.
  assign rx_almost_full  = (rx_cnt >= CNT_W'(RX_AF_LEVEL));
  assign rx_full         = (rx_cnt >= cap);
  assign tx_almost_empty = (tx_cnt <= CNT_W'(TX_AE_LEVEL));
  assign tx_empty        = (tx_cnt == '0);

  assign fifo_index = {{TOP_W{1'b0}}, rx_cnt, {GAP_W{1'b0}}, tx_cnt};
endmodule

// File: rtl/efifo_chk.sv
module efifo_chk
  import efifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_in_valid,
  input logic               rx_in_ready,
  input logic               rx_out_valid,
  input logic               rx_out_ready,
  input logic               tx_wr_valid,
  input logic               tx_wr_ready,
  input logic               tx_take,
  input logic               fcr_wr,
  input logic [CTL_W-1:0]   fcr_wdata,
  input logic [CTL_W-1:0]   fcr_rdata,
  input logic [IDX_W-1:0]   fifo_index,
  input logic               rx_overrun,
  input logic               rx_almost_full
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] rx_lvl, tx_lvl;
  assign rx_lvl = fifo_index[IDX_RX_LSB +: CNT_W];
  assign tx_lvl = fifo_index[IDX_TX_LSB +: CNT_W];

  AST_RX_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl <= CNT_W'(DEPTH)) && (tx_lvl <= CNT_W'(DEPTH))); // R3

  AST_EMPTY_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl == '0) |-> !rx_out_valid); // R5

  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_in_ready && !rx_out_ready && !fcr_wr && !fcr_rdata[CTL_RXRST_BIT])
    |=> (rx_overrun && $stable(rx_lvl))); // R4

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_in_valid && !rx_in_ready)); // R4

  AST_AF_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_almost_full) |-> $past(rx_in_valid && rx_in_ready)); // R6

  AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_wdata[CTL_RXRST_BIT]) |=> ((rx_lvl == '0) && fcr_rdata[CTL_RXRST_BIT])); // R9

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_valid && !tx_wr_ready && !tx_take && !fcr_wr) |=> $stable(tx_lvl)); // R7
endmodule

bind rx_err_fifo efifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_in_valid    (rx_in_valid),
  .rx_in_ready    (rx_in_ready),
  .rx_out_valid   (rx_out_valid),
  .rx_out_ready   (rx_out_ready),
  .tx_wr_valid    (tx_wr_valid),
  .tx_wr_ready    (tx_wr_ready),
  .tx_take        (tx_take),
  .fcr_wr         (fcr_wr),
  .fcr_wdata      (fcr_wdata),
  .fcr_rdata      (fcr_rdata),
  .fifo_index     (fifo_index),
  .rx_overrun     (rx_overrun),
  .rx_almost_full (rx_almost_full)
);

// File: tb/rx_err_fifo_tb.sv
module rx_err_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int RST_CYC    = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_in_valid = 0, rx_in_perr = 0, rx_in_ferr = 0;
  logic [7:0] rx_in_data = 0;
  logic       rx_out_ready = 0;
  logic       tx_wr_valid = 0, tx_take = 0;
  logic       fcr_wr = 0;
  logic [3:0] fcr_wdata = 0;
  logic       rx_in_ready, rx_out_valid, tx_wr_ready;
  logic [9:0] rx_out_data;
  logic [3:0] fcr_rdata;
  logic [15:0] fifo_index;
  logic       rx_overrun, rx_almost_full, rx_full, tx_almost_empty, tx_empty;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [9:0] sb_q[$];
  int model_cap = 1;
  int model_tx  = 0;

  rx_err_fifo u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(rx_in_data), .rx_in_perr(rx_in_perr), .rx_in_ferr(rx_in_ferr),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_wr_valid(tx_wr_valid), .tx_wr_ready(tx_wr_ready), .tx_take(tx_take),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .fcr_rdata(fcr_rdata),
    .fifo_index(fifo_index), .rx_overrun(rx_overrun), .rx_almost_full(rx_almost_full),
    .rx_full(rx_full), .tx_almost_empty(tx_almost_empty), .tx_empty(tx_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic check_idx(string req, int rxc, int txc);
    check(req, int'(fifo_index), (rxc << 8) | txc);
  endtask

  // Monitor: every pop is compared with the scoreboard head (R2).
  always @(negedge clk) begin
    if (rst_n && rx_out_valid && rx_out_ready) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: actual 0x%0h expected no entry", rx_out_data);
      end else begin
        if (rx_out_data !== sb_q[0]) begin
          n_fail++;
          $display("FAIL R2: actual 0x%0h expected 0x%0h", rx_out_data, sb_q[0]);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic push_rx(logic [7:0] d, logic p, logic f, output bit acc);
    acc = (sb_q.size() < model_cap);
    rx_in_valid = 1; rx_in_data = d; rx_in_perr = p; rx_in_ferr = f;
    cycle();
    rx_in_valid = 0;
    if (acc) sb_q.push_back({f, p, d});
  endtask

  task automatic drain();
    rx_out_ready = 1;
    for (int i = 0; i < 4*DEPTH; i++) begin
      cycle();
      if (sb_q.size() == 0) break;
    end
    rx_out_ready = 0;
  endtask

  task automatic write_ctl(logic [3:0] v);
    fcr_wr = 1; fcr_wdata = v;
    cycle();
    fcr_wr = 0; fcr_wdata = 0;
    model_cap = v[0] ? DEPTH : 1;
  endtask

  task automatic tx_write();
    tx_wr_valid = 1;
    cycle();
    tx_wr_valid = 0;
    if (model_tx < model_cap) model_tx++;
  endtask

  task automatic tx_take_one();
    tx_take = 1;
    cycle();
    tx_take = 0;
    if (model_tx > 0) model_tx--;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (3) cycle();
    // R1: reset state
    check("R1 index", int'(fifo_index), 0);
    check("R1 ctl", int'(fcr_rdata), 0);
    check("R1 valid", int'(rx_out_valid), 0);
    check("R1 data", int'(rx_out_data), 0);
    check("R1 flags", int'({rx_overrun, rx_almost_full, tx_empty, tx_almost_empty}), 4'b0011);
    rst_n = 1;
    cycle();

    // R10: single-entry mode, second push overruns
    push_rx(8'hA5, 1'b0, 1'b0, acc);
    check_idx("R10 one entry", 1, 0);
    push_rx(8'h11, 1'b1, 1'b1, acc);
    check("R10 overrun in single mode", int'(rx_overrun), 1);
    check_idx("R10 count held", 1, 0);
    drain();
    check_idx("R10 drained", 0, 0);

    write_ctl(4'h1);
    check("R10 mode readback", int'(fcr_rdata), 1);

    // R2/R6/R3: fill with mixed tags, watch almost-full boundary
    for (int i = 0; i < DEPTH; i++) begin
      push_rx(8'(8'h30 + i*7), 1'(i % 3 == 1), 1'(i % 4 == 2), acc);
      if (i == 10) check("R6 at 11", int'(rx_almost_full), 0);
      if (i == 11) check("R6 at 12", int'(rx_almost_full), 1);
    end
    check_idx("R3 full index", DEPTH, 0);
    check("R4 not ready when full", int'(rx_in_ready), 0);
    // R4: overrun drops the character
    push_rx(8'hEE, 1'b1, 1'b0, acc);
    check("R4 overrun pulse", int'(rx_overrun), 1);
    check_idx("R4 count unchanged", DEPTH, 0);
    cycle();
    check("R4 pulse one cycle", int'(rx_overrun), 0);
    drain();
    check_idx("R2 drained", 0, 0);

    // R5: reads of an empty queue
    rx_out_ready = 1;
    repeat (3) cycle();
    check("R5 data zero", int'(rx_out_data), 0);
    check("R5 not valid", int'(rx_out_valid), 0);
    check_idx("R5 count zero", 0, 0);
    rx_out_ready = 0;

    // R11: simultaneous push and pop
    for (int i = 0; i < 3; i++) push_rx(8'(i + 1), 1'b0, 1'(i == 1), acc);
    rx_out_ready = 1;
    push_rx(8'h77, 1'b1, 1'b1, acc);
    rx_out_ready = 0;
    check_idx("R11 count unchanged", 3, 0);
    drain();

    // R7/R8: transmit counter
    for (int i = 0; i < DEPTH + 1; i++) begin
      tx_write();
      if (model_tx == 4 && i == 3) check("R8 ae at 4", int'(tx_almost_empty), 1);
      if (model_tx == 5 && i == 4) check("R8 ae at 5", int'(tx_almost_empty), 0);
    end
    check_idx("R7 tx full", 0, DEPTH);
    check("R7 ready low at full", int'(tx_wr_ready), 0);
    for (int i = 0; i < DEPTH + 1; i++) tx_take_one();
    check_idx("R7 take on empty ignored", 0, 0);
    check("R8 tx empty", int'(tx_empty), 1);

    // R9: receive flush leaves transmit count alone
    for (int i = 0; i < 5; i++) push_rx(8'(8'hC0 + i), 1'b1, 1'b0, acc);
    for (int i = 0; i < 6; i++) tx_write();
    write_ctl(4'h9);
    sb_q.delete();
    check_idx("R9 rx flushed", 0, 6);
    check("R9 rx busy", int'(fcr_rdata), 4'h9);
    repeat (RST_CYC - 1) cycle();
    check("R9 rx busy last", int'(fcr_rdata[3]), 1);
    cycle();
    check("R9 rx busy cleared", int'(fcr_rdata), 4'h1);
    write_ctl(4'h5);
    model_tx = 0;
    check_idx("R9 tx flushed", 0, 0);
    check("R9 tx busy", int'(fcr_rdata), 4'h5);
    repeat (RST_CYC) cycle();
    check("R9 tx busy cleared", int'(fcr_rdata), 4'h1);
    push_rx(8'h5A, 1'b0, 1'b1, acc);
    drain();
    check_idx("R9 usable after flush", 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule